// File: doc/BRIEF.md
# Target Program-Mode Entry and Executive Check Sequencer

This block sits on the programmer side of a serial in-circuit programming link. One start request makes it drive the target's reset line, serial clock and serial data so that the target enters its serial program/verify mode. The entry follows a fixed order: a short high pulse on reset, a quiet gap, a 32-bit entry key shifted out most significant bit first, and then reset raised and held for the rest of the session.

After a settling interval the sequencer makes one read through a plain request/valid port. The read fetches an identifier byte from a fixed address. If the byte equals the magic value, the helper firmware in the target counts as resident. Any other byte, or no answer before a timeout, means the firmware must be loaded. The block ends each session with a one-cycle done pulse. It then holds exactly one of two status flags until the next start. The encoding of the read command on the wire and the firmware download are handled elsewhere.

Top module: `prog_entry_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start, every output except `rd_addr_o` is low: `tgt_rst_o`, `ser_clk_o`, `ser_dat_o`, `rd_req_o`, `done_o`, `resident_o` and `need_load_o`.
- R2: A start accepted in idle drives `tgt_rst_o` high for exactly PULSE_CYC cycles, starting in the cycle after the start is sampled. It then drives `tgt_rst_o` low for GAP_CYC cycles, with `ser_clk_o` and `ser_dat_o` low during that gap.
- R3: The key 0x4D434850 is then shifted out most significant bit first, one bit every 2*HALF_DIV cycles. `ser_dat_o` carries the bit for the whole bit period. `ser_clk_o` is low for the first HALF_DIV cycles of the bit period and high for the last HALF_DIV cycles.
- R4: In the cycle after the high phase of the last key bit, `tgt_rst_o` goes high. It stays high through the read, after done, and until the next accepted start.
- R5: `rd_req_o` rises exactly max(HOLD_A_CYC, HOLD_B_CYC) cycles after `tgt_rst_o` is raised. It stays high until a response is accepted or the timeout expires, and it is never high while `tgt_rst_o` is low.
- R6: While `rd_req_o` is high, `rd_addr_o` is 0x807F0.
- R7: A response is accepted at a clock edge where both `rd_req_o` and `rd_vld_i` are high. In the next cycle `done_o` is high for one cycle. In that same cycle `resident_o` becomes 1 if `rd_data_i` was 0xBB, and `need_load_o` becomes 1 otherwise. Both flags hold until the next accepted start clears them.
- R8: A start that arrives while a session is running is ignored. The sequence continues unchanged.
- R9: If no response arrives within TIMEOUT_CYC request cycles, the session ends with done and `need_load_o`. A response in the last of those cycles still counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a session (sampled in idle only) |
| tgt_rst_o | output | 1 | Target reset / mode line |
| ser_clk_o | output | 1 | Serial clock to target |
| ser_dat_o | output | 1 | Serial data to target |
| rd_req_o | output | 1 | Identifier read request |
| rd_addr_o | output | ADDR_W | Identifier read address |
| rd_vld_i | input | 1 | Read response valid |
| rd_data_i | input | DATA_W | Read response data |
| done_o | output | 1 | One-cycle end-of-session pulse |
| resident_o | output | 1 | Identifier matched: firmware resident |
| need_load_o | output | 1 | Mismatch or timeout: firmware must be loaded |

## Verification
The hardest corner to reach from the ports is a response that arrives in the very last request cycle, where the valid answer and the expiring timeout coincide. The bench's responder counts request cycles and raises valid after a programmable delay. Setting that delay to TIMEOUT_CYC-1 lands the response exactly on the expiry cycle. A second hard case is a start pulse in the middle of the key. The bench injects one during a session and checks that the reset line stays low in the cycle where a restart would have raised it.

// File: rtl/pes_pkg.sv
package pes_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_GAP,
    ST_KEY,
    ST_SETTLE,
    ST_READ
  } seq_state_t;

  localparam logic [31:0] ENTRY_KEY = 32'h4D43_4850;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pes_interval_timer.sv
module pes_interval_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

  AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && zero_o) |=> zero_o); // R2

endmodule

// File: rtl/pes_key_shifter.sv
module pes_key_shifter #(
  parameter int unsigned KEY_W    = 32,
  parameter int unsigned HALF_DIV = 4,
  parameter logic [KEY_W-1:0] KEY = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic last_o,
  output logic sclk_o,
  output logic sdat_o
);

  localparam int unsigned DIV_W = $clog2(HALF_DIV + 1);
  localparam int unsigned BIT_W = $clog2(KEY_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(KEY_W - 1);

  logic             act_q, act_d;
  logic             high_q, high_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [KEY_W-1:0] sh_q, sh_d;
  logic             phase_end;

  always_comb begin
    act_d     = act_q;
    high_d    = high_q;
    div_d     = div_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    phase_end = act_q && (div_q == DIV_LAST);
    last_o    = phase_end && high_q && (bit_q == BIT_LAST);
    if (go_i) begin
      act_d  = 1'b1;
      high_d = 1'b0;
      div_d  = '0;
      bit_d  = '0;
      sh_d   = KEY;
    end else if (act_q) begin
      if (!phase_end) begin
        div_d = div_q + 1'b1;
      end else begin
        div_d = '0;
        if (!high_q) begin
          high_d = 1'b1;
        end else begin
          high_d = 1'b0;
          if (bit_q == BIT_LAST) begin
            act_d = 1'b0;
          end else begin
            bit_d = bit_q + 1'b1;
            sh_d  = {sh_q[KEY_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      high_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else begin
      act_q  <= act_d;
      high_q <= high_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
    end
  end

  assign sclk_o = act_q && high_q;
  assign sdat_o = act_q && sh_q[KEY_W-1];

  AST_DATA_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $stable(sdat_o)); // R3

  AST_CLOCK_ONLY_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> (!sclk_o && !sdat_o)); // R3

endmodule

// File: rtl/pes_id_reader.sv
module pes_id_reader #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned TIMEOUT_CYC = 1000,
  parameter logic [DATA_W-1:0] MAGIC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  output logic              rd_req_o,
  input  logic              rd_vld_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              fin_o,
  output logic              hit_o
);

  localparam int unsigned TMO_W = $clog2(TIMEOUT_CYC + 1);

  logic             act_q, act_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;

  always_comb begin
    fin_o = act_q && (rd_vld_i || (tmo_q == '0));
    hit_o = act_q && rd_vld_i && (rd_data_i == MAGIC);
    act_d = act_q;
    tmo_d = tmo_q;
    if (go_i) begin
      act_d = 1'b1;
      tmo_d = TMO_W'(TIMEOUT_CYC - 1);
    end else if (act_q) begin
      if (fin_o) begin
        act_d = 1'b0;
      end else begin
        tmo_d = tmo_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      tmo_q <= '0;
    end else begin
      act_q <= act_d;
      tmo_q <= tmo_d;
    end
  end

  assign rd_req_o = act_q;

  AST_REQ_HELD_UNTIL_END: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_vld_i && (tmo_q != '0)) |=> rd_req_o); // R5

  AST_REQ_DROPS_AFTER_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_vld_i && !go_i) |=> !rd_req_o); // R7

endmodule

// File: rtl/prog_entry_seq.sv
module prog_entry_seq
  import pes_pkg::*;
#(
  parameter int unsigned PULSE_CYC   = 4,
  parameter int unsigned GAP_CYC     = 8,
  parameter int unsigned HALF_DIV    = 4,
  parameter int unsigned HOLD_A_CYC  = 16,
  parameter int unsigned HOLD_B_CYC  = 24,
  parameter int unsigned TIMEOUT_CYC = 1000,
  parameter int unsigned KEY_W       = 32,
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned DATA_W      = 8,
  parameter logic [KEY_W-1:0]  KEY      = ENTRY_KEY,
  parameter logic [ADDR_W-1:0] ID_ADDR  = 24'h0807F0,
  parameter logic [DATA_W-1:0] ID_MAGIC = 8'hBB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              tgt_rst_o,
  output logic              ser_clk_o,
  output logic              ser_dat_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_vld_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              done_o,
  output logic              resident_o,
  output logic              need_load_o
);

  localparam int unsigned SETTLE_CYC = max_u(HOLD_A_CYC, HOLD_B_CYC);
  localparam int unsigned MAX_CYC    = max_u(max_u(PULSE_CYC, GAP_CYC), SETTLE_CYC);
  localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

  seq_state_t       st_q, st_d;
  logic             sess_q, sess_d;
  logic             done_q, done_d;
  logic             res_q, res_d;
  logic             need_q, need_d;
  logic             tm_load;
  logic [CNT_W-1:0] tm_val;
  logic             tm_zero;
  logic             key_go, key_last;
  logic             rd_go, rd_fin, rd_hit;

  pes_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tm_load),
    .load_val_i (tm_val),
    .zero_o     (tm_zero)
  );

  pes_key_shifter #(.KEY_W(KEY_W), .HALF_DIV(HALF_DIV), .KEY(KEY)) u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (key_go),
    .last_o (key_last),
    .sclk_o (ser_clk_o),
    .sdat_o (ser_dat_o)
  );

  pes_id_reader #(.DATA_W(DATA_W), .TIMEOUT_CYC(TIMEOUT_CYC), .MAGIC(ID_MAGIC)) u_reader (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (rd_go),
    .rd_req_o  (rd_req_o),
    .rd_vld_i  (rd_vld_i),
    .rd_data_i (rd_data_i),
    .fin_o     (rd_fin),
    .hit_o     (rd_hit)
  );

  always_comb begin
    st_d    = st_q;
    sess_d  = sess_q;
    done_d  = 1'b0;
    res_d   = res_q;
    need_d  = need_q;
    tm_load = 1'b0;
    tm_val  = '0;
    key_go  = 1'b0;
    rd_go   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d    = ST_PULSE;
          tm_load = 1'b1;
          tm_val  = CNT_W'(PULSE_CYC - 1);
          sess_d  = 1'b0;
          res_d   = 1'b0;
          need_d  = 1'b0;
        end
      end
      ST_PULSE: begin
        if (tm_zero) begin
          st_d    = ST_GAP;
          tm_load = 1'b1;
          tm_val  = CNT_W'(GAP_CYC - 1);
        end
      end
      ST_GAP: begin
        if (tm_zero) begin
          st_d   = ST_KEY;
          key_go = 1'b1;
        end
      end
      ST_KEY: begin
        if (key_last) begin
          st_d    = ST_SETTLE;
          tm_load = 1'b1;
          tm_val  = CNT_W'(SETTLE_CYC - 1);
          sess_d  = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (tm_zero) begin
          st_d  = ST_READ;
          rd_go = 1'b1;
        end
      end
      ST_READ: begin
        if (rd_fin) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          res_d  = rd_hit;
          need_d = !rd_hit;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sess_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= 1'b0;
      need_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sess_q <= sess_d;
      done_q <= done_d;
      res_q  <= res_d;
      need_q <= need_d;
    end
  end

  assign tgt_rst_o   = (st_q == ST_PULSE) || sess_q;
  assign rd_addr_o   = ID_ADDR;
  assign done_o      = done_q;
  assign resident_o  = res_q;
  assign need_load_o = need_q;

  AST_REQ_NEEDS_RAISED_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> tgt_rst_o); // R5

  AST_ONE_STATUS_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    !(resident_o && need_load_o)); // R7

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_DONE_CARRIES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (resident_o || need_load_o)); // R7

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q inside {ST_GAP, ST_KEY, ST_SETTLE, ST_READ}) |=> (st_q != ST_PULSE)); // R8

  AST_NO_CLOCK_IN_SESSION_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rst_o |-> !ser_clk_o); // R4

endmodule

// File: tb/prog_entry_seq_tb_top.sv
`timescale 1ns/1ps
module prog_entry_seq_tb_top;

  localparam int P  = 3;
  localparam int G  = 4;
  localparam int H  = 2;
  localparam int HA = 5;
  localparam int HB = 7;
  localparam int T  = 10;
  localparam int S  = (HA > HB) ? HA : HB;
  localparam int K0 = P + G;
  localparam int KE = K0 + 64 * H;
  localparam int R0 = KE + S;
  localparam logic [31:0] EXP_KEY = 32'h4D434850;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        tgt_rst_o, ser_clk_o, ser_dat_o, rd_req_o;
  logic [23:0] rd_addr_o;
  logic        rd_vld_i;
  logic [7:0]  rd_data_i;
  logic        done_o, resident_o, need_load_o;

  prog_entry_seq #(
    .PULSE_CYC(P), .GAP_CYC(G), .HALF_DIV(H),
    .HOLD_A_CYC(HA), .HOLD_B_CYC(HB), .TIMEOUT_CYC(T)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .tgt_rst_o(tgt_rst_o), .ser_clk_o(ser_clk_o), .ser_dat_o(ser_dat_o),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_vld_i(rd_vld_i),
    .rd_data_i(rd_data_i), .done_o(done_o), .resident_o(resident_o),
    .need_load_o(need_load_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // reference model state
  bit m_busy, m_sess, m_done, m_res, m_need;
  int m_t;
  bit cmp_en;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_sess = 0; m_done = 0; m_res = 0; m_need = 0; m_t = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start_i) begin
          m_busy = 1; m_t = 0; m_sess = 0; m_res = 0; m_need = 0;
        end
      end else if (m_t >= R0) begin
        if (rd_vld_i) begin
          m_busy = 0; m_done = 1; m_res = (rd_data_i == 8'hBB); m_need = !m_res;
        end else if (m_t == R0 + T - 1) begin
          m_busy = 0; m_done = 1; m_res = 0; m_need = 1;
        end else begin
          m_t++;
        end
      end else begin
        m_t++;
        if (m_t == KE) m_sess = 1;
      end
      cmp_en = 1;
    end
  end

  // responder: raises valid after rsp_delay request cycles (-1: never)
  int rsp_delay = -1;
  int rcnt = 0;
  always @(negedge clk) begin
    if (rd_req_o) begin
      rd_vld_i = (rsp_delay >= 0) && (rcnt == rsp_delay);
      rcnt++;
    end else begin
      rd_vld_i = 1'b0;
      rcnt = 0;
    end
  end

  // per-cycle comparison against the model, plus key capture
  logic [31:0] key_cap;
  int key_bits;
  bit prev_clk;
  always @(negedge clk) begin
    bit e_rst, e_clk, e_dat, e_req;
    int u;
    e_clk = 0; e_dat = 0;
    e_rst = (m_busy && m_t < P) || m_sess;
    if (m_busy && m_t >= K0 && m_t < KE) begin
      u = m_t - K0;
      e_clk = (u % (2 * H)) >= H;
      e_dat = EXP_KEY[31 - u / (2 * H)];
    end
    e_req = m_busy && m_t >= R0;
    if (cmp_en) begin
      chk(tgt_rst_o == e_rst, "R2/R4 tgt_rst_o", 32'(tgt_rst_o), 32'(e_rst));
      chk(ser_clk_o == e_clk, "R3 ser_clk_o", 32'(ser_clk_o), 32'(e_clk));
      chk(ser_dat_o == e_dat, "R3 ser_dat_o", 32'(ser_dat_o), 32'(e_dat));
      chk(rd_req_o == e_req, "R5 rd_req_o", 32'(rd_req_o), 32'(e_req));
      chk(done_o == m_done, "R7 done_o", 32'(done_o), 32'(m_done));
      chk(resident_o == m_res, "R7 resident_o", 32'(resident_o), 32'(m_res));
      chk(need_load_o == m_need, "R7 need_load_o", 32'(need_load_o), 32'(m_need));
      if (rd_req_o) chk(rd_addr_o == 24'h0807F0, "R6 rd_addr_o", 32'(rd_addr_o), 32'h0807F0);
    end
    if (ser_clk_o && !prev_clk) begin
      key_cap = {key_cap[30:0], ser_dat_o};
      key_bits++;
    end
    prev_clk = ser_clk_o;
  end

  task automatic session(input int delay, input logic [7:0] data, input bit exp_res,
                         input bit poke, input string tag);
    int guard;
    rsp_delay = delay;
    rd_data_i = data;
    key_cap = '0;
    key_bits = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    if (poke) begin
      repeat (8) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      chk(tgt_rst_o == 1'b0, "R8 start while busy restarted", 32'(tgt_rst_o), 32'h0);
    end
    guard = 0;
    while (!done_o && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    chk(done_o == 1'b1, {tag, " done seen"}, 32'(done_o), 32'h1);
    chk(resident_o == exp_res, {tag, " resident_o"}, 32'(resident_o), 32'(exp_res));
    chk(need_load_o == !exp_res, {tag, " need_load_o"}, 32'(need_load_o), 32'(!exp_res));
    chk(key_cap == EXP_KEY && key_bits == 32, "R3 captured key", key_cap, EXP_KEY);
    repeat (6) @(negedge clk);
    chk(resident_o == exp_res && tgt_rst_o, "R4/R7 status and reset held after done",
        {30'h0, tgt_rst_o, resident_o}, {30'h0, 1'b1, exp_res});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: session never completed act=0 exp=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    rd_vld_i = 1'b0;
    rd_data_i = 8'h00;
    cmp_en = 0;
    prev_clk = 0;
    key_cap = '0;
    key_bits = 0;
    repeat (3) @(negedge clk);
    chk({tgt_rst_o, ser_clk_o, ser_dat_o, rd_req_o, done_o, resident_o, need_load_o} == 7'b0,
        "R1 outputs in reset", 32'({tgt_rst_o, ser_clk_o, ser_dat_o, rd_req_o, done_o}), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({tgt_rst_o, rd_req_o, done_o, resident_o, need_load_o} == 5'b0,
        "R1 outputs idle after reset", 32'({tgt_rst_o, rd_req_o, done_o}), 32'h0);
    session(2, 8'hBB, 1'b1, 1'b1, "R7 magic match");
    session(0, 8'hBA, 1'b0, 1'b0, "R7 near-miss byte");
    session(-1, 8'hBB, 1'b0, 1'b0, "R9 timeout");
    session(T - 1, 8'hBB, 1'b1, 1'b0, "R9 answer in last cycle");
    session(4, 8'h00, 1'b0, 1'b0, "R7 zero byte");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule